// File: doc/BRIEF.md
# Trimmed 100 Hz Time-Base Prescaler

This block turns a 32768 Hz oscillator clock into the 10 ms update strobe that drives a real-time clock's counters. A phase accumulator adds a fixed step on every oscillator cycle it is allowed to see. Each time the accumulator passes the oscillator rate it emits a one-cycle tick. The tick spacing therefore alternates between 327 and 328 cycles, and each second holds exactly 100 ticks.

A crystal that runs fast is corrected by deleting oscillator cycles from the divider. A correction window of 1,015,808 raw cycles (31 s) repeats without end. At each window boundary the 8-bit trim input is captured. The divider then skips that many cycles, one per cycle, starting at the first cycle of the window. Each step slows the time base by about 0.984 ppm, so the full value 0xFF gives about 251 ppm. A test input blocks all deletion. A second test input makes the tick run 32 times faster. A tuning-mode input sends a 100 Hz, 20 % duty waveform toward the interrupt pin, so the crystal error can be measured.

Top module: `trim_prescaler`

## Requirements
- R1: While rst_n is low at a clock edge, tick and cal_wave are 0 after that edge. The window position, the pending deletion count and the accumulator all clear, so the first window after reset deletes no cycles.
- R2: With no deletion, every OSC_HZ oscillator cycles produce exactly TICK_HZ ticks. Consecutive ticks are floor(OSC_HZ/TICK_HZ) or that value plus one cycles apart.
- R3: In the cycle that ends a window, trim_val is captured. The first trim_val cycles of the next window are deleted, and a deleted cycle does not advance the accumulator.
- R4: A captured trim value of 0 deletes no cycles, so tick timing is the same as in R2.
- R5: A change of trim_val in the middle of a window has no effect until the next window boundary.
- R6: While trim_off is 1, no cycle is deleted, whatever trim value is pending.
- R7: While accel is 1, the accumulator step is ACCEL times TICK_HZ, so ticks come ACCEL times as often.
- R8: While tune_mode is 1, cal_wave is high when the accumulator is below OSC_HZ/5 (about 20 % of each 10 ms period). cal_wave is 0 one cycle after tune_mode is 0.
- R9: tick is a strobe that lasts one cycle and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trim_val | input | TRIM_W | Number of cycles to delete per window |
| trim_off | input | 1 | Test bit: blocks deletion |
| accel | input | 1 | Test bit: tick rate multiplied by ACCEL |
| tune_mode | input | 1 | Enables the 100 Hz calibration waveform |
| tick | output | 1 | 10 ms update strobe, one cycle wide |
| cal_wave | output | 1 | 100 Hz waveform with 20 % duty while tuning |

## Verification
The bench looks at the window boundary. A design that captured the trim value one cycle late, or deleted one cycle too many, would move a tick by a cycle in the following window. It changes trim_val in the middle of a window; a design that read the live input would delay ticks a window early. It holds trim_off with the maximum trim value pending, and a design that ignored the test bit would lose 255 cycles per window. It also counts ticks over exactly one second, and measures tick spacing in both the normal and the accelerated rate. A wrong step or a wrong wrap compare would give 99 or 101 ticks, or spacings outside the two allowed values.

// File: rtl/trim_pkg.sv
// Shared types for the trimmed time-base prescaler.
package trim_pkg;
    // Rate selection for the phase accumulator step.
    typedef enum logic {
        RATE_NORMAL = 1'b0,
        RATE_FAST   = 1'b1
    } rate_e;
endpackage

// File: rtl/trim_window.sv
// Correction window: counts raw oscillator cycles in windows of WIN_CYC.
// At the last cycle of a window it captures the trim input as a pending
// deletion count. Cycles are then withheld from the divider one at a time
// at the start of the new window. Assumes trim values below WIN_CYC.
module trim_window #(
    parameter int WIN_CYC = 1015808,
    parameter int TRIM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRIM_W-1:0] trim_val,
    input  logic              trim_off,
    output logic              pass
);
    localparam int WIN_W = $clog2(WIN_CYC);

    logic [WIN_W-1:0]  win_pos;
    logic [TRIM_W-1:0] left_q;
    logic              win_end;

    assign win_end = (win_pos == WIN_W'(WIN_CYC - 1));

    // Raw cycle position within the current window.
    always_ff @(posedge clk) begin
        if (!rst_n)       win_pos <= '0;
        else if (win_end) win_pos <= '0;
        else              win_pos <= win_pos + 1'b1;
    end

    // Pending deletions: loaded from trim_val at the window end, then counted down.
    always_ff @(posedge clk) begin
        if (!rst_n)            left_q <= '0;
        else if (win_end)      left_q <= trim_val;
        else if (left_q != '0) left_q <= left_q - 1'b1;
    end

    // A cycle reaches the divider unless a deletion is pending and allowed.
    always_comb begin
        pass = 1'b1;
        if (left_q != '0 && !trim_off) pass = 1'b0;
    end
endmodule

// File: rtl/frac_div.sv
// Fractional divider: a phase accumulator adds a step on each passed cycle.
// When it reaches OSC_HZ it wraps and issues a registered one-cycle tick.
// Assumes that ACCEL*TICK_HZ is below OSC_HZ.
module frac_div
    import trim_pkg::*;
#(
    parameter int OSC_HZ  = 32768,
    parameter int TICK_HZ = 100,
    parameter int ACCEL   = 32,
    parameter int ACC_W   = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  rate_e            rate,
    output logic             tick,
    output logic [ACC_W-1:0] acc
);
    localparam logic [ACC_W-1:0] LIMIT     = ACC_W'(OSC_HZ);
    localparam logic [ACC_W-1:0] STEP_SLOW = ACC_W'(TICK_HZ);
    localparam logic [ACC_W-1:0] STEP_FAST = ACC_W'(TICK_HZ * ACCEL);

    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] sum;
    logic             wrap;

    // Step choice; a build without acceleration keeps a constant step.
    generate
        if (ACCEL > 1) begin : g_rate_mux
            assign step = (rate == RATE_FAST) ? STEP_FAST : STEP_SLOW;
        end else begin : g_rate_fixed
            assign step = STEP_SLOW;
        end
    endgenerate

    assign sum  = acc + step;
    assign wrap = (sum >= LIMIT);

    // Accumulator update and registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= adv && wrap;
            if (adv) acc <= wrap ? (sum - LIMIT) : sum;
        end
    end
endmodule

// File: rtl/cal_wave_gen.sv
// Calibration waveform: high while the accumulator phase is below CAL_LIM.
// This gives a fixed duty at the tick rate. Gated by tuning mode and registered.
module cal_wave_gen #(
    parameter int ACC_W   = 17,
    parameter int CAL_LIM = 6553
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc,
    input  logic             tune_mode,
    output logic             wave
);
    // Registered waveform output.
    always_ff @(posedge clk) begin
        if (!rst_n) wave <= 1'b0;
        else        wave <= tune_mode && (acc < ACC_W'(CAL_LIM));
    end
endmodule

// File: rtl/trim_prescaler.sv
// Trimmed time-base prescaler: oscillator clock in, 10 ms strobe out.
// Deletes trim_val oscillator cycles at the start of each correction window.
// Assumes that clk is the oscillator and that the inputs are synchronous to it.
module trim_prescaler #(
    parameter int OSC_HZ  = 32768,
    parameter int TICK_HZ = 100,
    parameter int ACCEL   = 32,
    parameter int WIN_CYC = 1015808,
    parameter int TRIM_W  = 8,
    parameter int CAL_DIV = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRIM_W-1:0] trim_val,
    input  logic              trim_off,
    input  logic              accel,
    input  logic              tune_mode,
    output logic              tick,
    output logic              cal_wave
);
    import trim_pkg::*;

    localparam int ACC_W   = $clog2(OSC_HZ + TICK_HZ * ACCEL) + 1;
    localparam int CAL_LIM = OSC_HZ / CAL_DIV;

    logic             slot_pass;
    logic [ACC_W-1:0] phase_acc;
    rate_e            rate_sel;

    // Test bit to rate encoding.
    assign rate_sel = accel ? RATE_FAST : RATE_NORMAL;

    trim_window #(.WIN_CYC(WIN_CYC), .TRIM_W(TRIM_W)) win_i (
        .clk(clk), .rst_n(rst_n), .trim_val(trim_val),
        .trim_off(trim_off), .pass(slot_pass)
    );

    frac_div #(.OSC_HZ(OSC_HZ), .TICK_HZ(TICK_HZ), .ACCEL(ACCEL), .ACC_W(ACC_W)) div_i (
        .clk(clk), .rst_n(rst_n), .adv(slot_pass), .rate(rate_sel),
        .tick(tick), .acc(phase_acc)
    );

    cal_wave_gen #(.ACC_W(ACC_W), .CAL_LIM(CAL_LIM)) cal_i (
        .clk(clk), .rst_n(rst_n), .acc(phase_acc),
        .tune_mode(tune_mode), .wave(cal_wave)
    );
endmodule

// File: rtl/trim_prescaler_chk.sv
// Property checker for the trimmed prescaler, attached by bind.
module trim_prescaler_chk #(
    parameter int ACC_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             cal_wave,
    input logic             tune_mode,
    input logic             trim_off,
    input logic             pass,
    input logic [ACC_W-1:0] acc
);
    // R9
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R8
    cal_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tune_mode |=> !cal_wave);

    // R3
    deleted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pass |=> $stable(acc));

    // R6
    trim_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trim_off |-> pass);
endmodule

bind trim_prescaler trim_prescaler_chk #(.ACC_W(ACC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cal_wave(cal_wave),
    .tune_mode(tune_mode), .trim_off(trim_off), .pass(slot_pass), .acc(phase_acc)
);

// File: tb/trim_prescaler_tb.sv
module trim_prescaler_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OSC   = 8192;
    localparam int TICKS = 100;
    localparam int ACC   = 32;
    localparam int WIN   = 6000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] trim_val = 8'd0;
    logic       trim_off = 1'b0;
    logic       accel = 1'b0;
    logic       tune_mode = 1'b0;
    logic       tick, cal_wave;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;
    string cur_req = "R1";

    // Behavioural reference state.
    int  m_pos = 0, m_left = 0, m_acc = 0;
    bit  exp_tick = 0, exp_cal = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trim_prescaler #(.OSC_HZ(OSC), .TICK_HZ(TICKS), .ACCEL(ACC), .WIN_CYC(WIN),
                     .TRIM_W(8), .CAL_DIV(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .trim_val(trim_val), .trim_off(trim_off),
        .accel(accel), .tune_mode(tune_mode), .tick(tick), .cal_wave(cal_wave)
    );

    // Reference model advanced on each edge from the requirement text.
    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            m_pos = 0; m_left = 0; m_acc = 0; exp_tick = 0; exp_cal = 0;
        end else begin
            bit ok;
            int st;
            ok = !(m_left > 0 && !trim_off);
            st = accel ? TICKS * ACC : TICKS;
            exp_tick = ok && (m_acc + st >= OSC);
            exp_cal  = tune_mode && (m_acc < OSC / 5);
            if (ok) m_acc = (m_acc + st >= OSC) ? m_acc + st - OSC : m_acc + st;
            if (m_pos == WIN - 1) m_left = trim_val;
            else if (m_left > 0) m_left = m_left - 1;
            m_pos = (m_pos == WIN - 1) ? 0 : m_pos + 1;
        end
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (tick !== exp_tick || cal_wave !== exp_cal) begin
                errors++;
                $display("FAIL %s tick/cal got %b/%b expected %b/%b", cur_req,
                         tick, cal_wave, exp_tick, exp_cal);
            end
        end
    end

    task automatic check(input string req, input int got, input int lo, input int hi);
        checks++;
        if (got < lo || got > hi) begin
            errors++;
            $display("FAIL %s got %0d expected %0d..%0d", req, got, lo, hi);
        end
    endtask

    // Count ticks and spacing over n cycles; returns count, min and max gaps.
    task automatic run_count(input int n, output int cnt, output int gmin,
                             output int gmax, output int hi_cyc);
        int last = -1;
        cnt = 0; gmin = 1 << 30; gmax = 0; hi_cyc = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cal_wave) hi_cyc++;
            if (tick) begin
                if (last >= 0) begin
                    if (i - last < gmin) gmin = i - last;
                    if (i - last > gmax) gmax = i - last;
                end
                last = i;
                cnt++;
            end
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        int c, gmin, gmax, hi;
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 tick in reset", tick, 0, 0);
        check("R1 cal in reset", cal_wave, 0, 0);
        trim_val = 8'd0; tune_mode = 1'b1;
        rst_n = 1'b1;
        // R2 R4 R8: one second with trim 0, 100 ticks, spacing 81/82, ~20 % duty
        cur_req = "R2";
        run_count(OSC, c, gmin, gmax, hi);
        check("R2 ticks per second", c, TICKS, TICKS);
        check("R2 min spacing", gmin, 81, 81);
        check("R2 max spacing", gmax, 82, 82);
        check("R8 duty high cycles", hi, 1600, 1680);
        cur_req = "R4";
        run_count(WIN, c, gmin, gmax, hi);
        check("R4 spacing with zero trim", gmin, 81, 82);
        // R3: deletion of 200 cycles at following boundaries
        cur_req = "R3";
        trim_val = 8'd200;
        run_count(2 * WIN, c, gmin, gmax, hi);
        check("R3 stretched gap present", gmax, 200, 300);
        // R5: change trim mid-window, effect only from next boundary
        cur_req = "R5";
        repeat (WIN / 3) @(negedge clk);
        trim_val = 8'd50;
        repeat (2 * WIN) @(negedge clk);
        // R6: maximum trim pending but blocked
        cur_req = "R6";
        trim_val = 8'd255; trim_off = 1'b1;
        run_count(2 * WIN, c, gmin, gmax, hi);
        check("R6 no gap stretched", gmax, 81, 82);
        // R7: accelerated rate, spacing 2 or 3
        cur_req = "R7";
        trim_off = 1'b0; trim_val = 8'd0;
        repeat (WIN) @(negedge clk);
        accel = 1'b1;
        repeat (2) @(negedge clk);
        run_count(OSC, c, gmin, gmax, hi);
        check("R7 fast min spacing", gmin, 2, 2);
        check("R7 fast max spacing", gmax, 3, 3);
        check("R7 fast tick count", c, TICKS * ACC - 1, TICKS * ACC + 1);
        // R9: spacing never 1 implies single-cycle strobe
        check("R9 no back-to-back ticks", gmin, 2, 1 << 20);
        // R8: tuning off drives the waveform low
        cur_req = "R8";
        accel = 1'b0; tune_mode = 1'b0;
        @(negedge clk);
        run_count(500, c, gmin, gmax, hi);
        check("R8 cal low without tuning", hi, 0, 0);
        // R1: reset mid-run clears outputs and pending deletions
        cur_req = "R1";
        trim_val = 8'd255; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 tick after reset", tick, 0, 0);
        rst_n = 1'b1;
        run_count(WIN - 10, c, gmin, gmax, hi);
        check("R1 first window untrimmed", gmax, 81, 82);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            finish_run();
        end
    end
endmodule